// File: doc/BRIEF.md
# OUT Endpoint Global-NAK Stop Controller

This block is the device-side control for halting every OUT endpoint of a USB device without losing received data. Software raises a global OUT NAK request. From then on the device refuses all new OUT data on every endpoint. The block reports the NAK state as effective only once the receive FIFO holds nothing. The receive FIFO's fill count comes in on an input, and the FIFO itself lies outside the block.

Once the effective state is reached, software stops each active OUT endpoint with a single write that sets the endpoint's enable, disable and set-NAK bits. The block completes the stop, clears the endpoint's enable and disable bits and raises a sticky per-endpoint "disabled" flag. Because the effective state already guarantees that the receive FIFO is empty, the sequence never includes a FIFO flush.

Each endpoint also keeps a NAK status bit. That bit survives the stop and is cleared only by an explicit clear-NAK write. When software drops the global request, endpoints that are enabled and not NAKed accept OUT data again.

Top module: `gonak_stop_ctrl`

## Requirements
- R1: A one-cycle `gnak_set` pulse makes `gnak_req` high after the next clock edge, and from then on every bit of `out_accept` is 0.
- R2: `gnak_eff` rises one clock edge after `gnak_req` is high, provided `rxf_level` is 0 at that edge. It stays low for as long as `rxf_level` is nonzero.
- R3: A `gnak_clr` pulse drops `gnak_req` and `gnak_eff` at the same edge. After that, `out_accept[i]` equals `ep_ena[i] & ~ep_nak[i]`.
- R4: An endpoint write with `wr_ena`=1 and `wr_dis`=0 sets that endpoint's `ep_ena` bit after the edge.
- R5: A write with `wr_ena`=1, `wr_dis`=1 and `wr_snak`=1 to an enabled endpoint sets its `ep_dis` and `ep_nak` bits. The disable stays pending, with `ep_ena` still 1, for as long as `gnak_eff` is low.
- R6: While the endpoint's `ep_dis` and `gnak_eff` are both high, the next edge clears `ep_ena` and `ep_dis` and sets the endpoint's `ep_disd` flag.
- R7: An `ep_disd` bit stays set until a pulse on the matching bit of `disd_clr`. Clear pulses on other bits leave it unchanged.
- R8: `ep_nak` stays set after a stop until a write with `wr_cnak`=1 and `wr_snak`=0. If `wr_snak` and `wr_cnak` are both 1, the bit is set.
- R9: A write with `wr_dis`=1 to an endpoint whose `ep_ena` is 0 changes neither its `ep_ena` nor its `ep_dis` bit, and no `ep_disd` flag follows.
- R10: A write selected by `wr_sel` changes only the bits of the selected endpoint.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gnak_set | input | 1 | Pulse: raise the global OUT NAK request |
| gnak_clr | input | 1 | Pulse: drop the global OUT NAK request (takes priority over set) |
| rxf_level | input | LVL_W | Receive FIFO occupancy count |
| wr_stb | input | 1 | Endpoint control write strobe |
| wr_sel | input | EP_W | Endpoint number for the write |
| wr_ena | input | 1 | Write: enable bit |
| wr_dis | input | 1 | Write: disable request bit |
| wr_snak | input | 1 | Write: set endpoint NAK |
| wr_cnak | input | 1 | Write: clear endpoint NAK |
| disd_clr | input | N_EP | Per-endpoint pulse that clears the disabled flag |
| gnak_req | output | 1 | Global OUT NAK request is active |
| gnak_eff | output | 1 | Global OUT NAK is in force and the receive FIFO is empty |
| ep_ena | output | N_EP | Endpoint enable bits |
| ep_dis | output | N_EP | Endpoint disable-pending bits |
| ep_nak | output | N_EP | Endpoint NAK status bits |
| ep_disd | output | N_EP | Sticky endpoint-disabled flags |
| out_accept | output | N_EP | Endpoint may accept OUT data |

## Verification
Every register sits one edge from its cause. Request, enable, disable-pending and NAK bits are due one edge after the write or pulse. `gnak_eff` is due one edge after `gnak_req` is seen with an empty FIFO. A stop completes one edge after both `ep_dis` and `gnak_eff` are high. The bench changes inputs on the falling edge and samples at the next falling edge, so each result it checks follows exactly one rising edge. Pending states are confirmed by holding the FIFO nonzero over several edges before checking.

// File: rtl/gonak_pkg.sv
package gonak_pkg;
  typedef struct packed {
    logic ena;
    logic dis;
    logic snak;
    logic cnak;
  } ep_cmd_t;
endpackage

// File: rtl/gonak_global.sv
module gonak_global #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             req_o,
  output logic             eff_o
);
  logic req_q, req_d, eff_q, eff_d;
  logic fifo_empty;

  assign fifo_empty = (level_i == '0);

  always_comb begin
    req_d = req_q;
    if (clr_i)      req_d = 1'b0;
    else if (set_i) req_d = 1'b1;
    eff_d = req_q && !clr_i && fifo_empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      eff_q <= 1'b0;
    end else begin
      req_q <= req_d;
      eff_q <= eff_d;
    end
  end

  assign req_o = req_q;
  assign eff_o = eff_q;

  AST_EFF_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eff_q) |-> $past(req_q) && ($past(level_i) == '0)); // R2
  AST_EFF_ONLY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    eff_q |-> req_q); // R3
  AST_CLR_DROPS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !req_q && !eff_q); // R3
endmodule

// File: rtl/gonak_ep_slot.sv
module gonak_ep_slot
  import gonak_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hit_i,
  input  ep_cmd_t cmd_i,
  input  logic    eff_i,
  input  logic    disd_clr_i,
  output logic    ena_o,
  output logic    dis_o,
  output logic    nak_o,
  output logic    disd_o
);
  logic ena_q, ena_d, dis_q, dis_d, nak_q, nak_d, disd_q, disd_d;
  logic done, upd_en;

  assign done   = dis_q && eff_i;
  assign upd_en = hit_i || done || disd_clr_i;

  always_comb begin
    ena_d  = ena_q;
    dis_d  = dis_q;
    nak_d  = nak_q;
    disd_d = disd_q;
    if (hit_i) begin
      if (cmd_i.ena && !cmd_i.dis) ena_d = 1'b1;
      if (cmd_i.dis && ena_q)      dis_d = 1'b1;
      if (cmd_i.snak)              nak_d = 1'b1;
      else if (cmd_i.cnak)         nak_d = 1'b0;
    end
    if (done) begin
      ena_d  = 1'b0;
      dis_d  = 1'b0;
      disd_d = 1'b1;
    end else if (disd_clr_i) begin
      disd_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q  <= 1'b0;
      dis_q  <= 1'b0;
      nak_q  <= 1'b0;
      disd_q <= 1'b0;
    end else if (upd_en) begin
      ena_q  <= ena_d;
      dis_q  <= dis_d;
      nak_q  <= nak_d;
      disd_q <= disd_d;
    end
  end

  assign ena_o  = ena_q;
  assign dis_o  = dis_q;
  assign nak_o  = nak_q;
  assign disd_o = disd_q;

  AST_DIS_HELD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q && !eff_i) |=> dis_q && ena_q); // R5
  AST_STOP_CLEARS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disd_q) |-> !ena_q && !dis_q && $past(eff_i)); // R6
  AST_NAK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (nak_q && !(hit_i && cmd_i.cnak && !cmd_i.snak)) |=> nak_q); // R8
  AST_DIS_NEEDS_ENA: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |-> ena_q); // R9
endmodule

// File: rtl/gonak_stop_ctrl.sv
module gonak_stop_ctrl
  import gonak_pkg::*;
#(
  parameter int N_EP  = 4,
  parameter int LVL_W = 8,
  localparam int EP_W = (N_EP > 1) ? $clog2(N_EP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gnak_set,
  input  logic             gnak_clr,
  input  logic [LVL_W-1:0] rxf_level,
  input  logic             wr_stb,
  input  logic [EP_W-1:0]  wr_sel,
  input  logic             wr_ena,
  input  logic             wr_dis,
  input  logic             wr_snak,
  input  logic             wr_cnak,
  input  logic [N_EP-1:0]  disd_clr,
  output logic             gnak_req,
  output logic             gnak_eff,
  output logic [N_EP-1:0]  ep_ena,
  output logic [N_EP-1:0]  ep_dis,
  output logic [N_EP-1:0]  ep_nak,
  output logic [N_EP-1:0]  ep_disd,
  output logic [N_EP-1:0]  out_accept
);
  ep_cmd_t cmd;
  logic    req_w, eff_w;

  assign cmd = '{ena: wr_ena, dis: wr_dis, snak: wr_snak, cnak: wr_cnak};

  gonak_global #(.LVL_W(LVL_W)) u_global (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (gnak_set),
    .clr_i   (gnak_clr),
    .level_i (rxf_level),
    .req_o   (req_w),
    .eff_o   (eff_w)
  );

  for (genvar i = 0; i < N_EP; i++) begin : g_ep
    logic hit;
    assign hit = wr_stb && (wr_sel == EP_W'(i));
    gonak_ep_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit_i      (hit),
      .cmd_i      (cmd),
      .eff_i      (eff_w),
      .disd_clr_i (disd_clr[i]),
      .ena_o      (ep_ena[i]),
      .dis_o      (ep_dis[i]),
      .nak_o      (ep_nak[i]),
      .disd_o     (ep_disd[i])
    );
    assign out_accept[i] = ep_ena[i] && !ep_nak[i] && !req_w;
  end

  assign gnak_req = req_w;
  assign gnak_eff = eff_w;

  AST_NO_ACCEPT_UNDER_GNAK: assert property (@(posedge clk) disable iff (!rst_n)
    gnak_req |-> (out_accept == '0)); // R1
  AST_REQ_AFTER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (gnak_set && !gnak_clr) |=> gnak_req); // R1
endmodule

// File: tb/tb_gonak_stop_ctrl.sv
module tb_gonak_stop_ctrl;
  localparam int N_EP = 4;
  localparam int LVL_W = 8;
  localparam int EP_W = 2;

  logic clk, rst_n;
  logic gnak_set, gnak_clr, wr_stb, wr_ena, wr_dis, wr_snak, wr_cnak;
  logic [LVL_W-1:0] rxf_level;
  logic [EP_W-1:0]  wr_sel;
  logic [N_EP-1:0]  disd_clr;
  logic gnak_req, gnak_eff;
  logic [N_EP-1:0] ep_ena, ep_dis, ep_nak, ep_disd, out_accept;

  int n_chk = 0;
  int n_err = 0;

  gonak_stop_ctrl #(.N_EP(N_EP), .LVL_W(LVL_W)) dut (
    .clk(clk), .rst_n(rst_n), .gnak_set(gnak_set), .gnak_clr(gnak_clr),
    .rxf_level(rxf_level), .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_ena(wr_ena),
    .wr_dis(wr_dis), .wr_snak(wr_snak), .wr_cnak(wr_cnak), .disd_clr(disd_clr),
    .gnak_req(gnak_req), .gnak_eff(gnak_eff), .ep_ena(ep_ena), .ep_dis(ep_dis),
    .ep_nak(ep_nak), .ep_disd(ep_disd), .out_accept(out_accept)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ep_write(input int ep, input logic e, input logic d, input logic s, input logic c);
    wr_stb = 1'b1; wr_sel = EP_W'(ep);
    wr_ena = e; wr_dis = d; wr_snak = s; wr_cnak = c;
    step(1);
    wr_stb = 1'b0; wr_ena = 1'b0; wr_dis = 1'b0; wr_snak = 1'b0; wr_cnak = 1'b0;
  endtask

  task automatic pulse_set();
    gnak_set = 1'b1; step(1); gnak_set = 1'b0;
  endtask

  task automatic pulse_clr();
    gnak_clr = 1'b1; step(1); gnak_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("reset gnak_req", 32'(gnak_req), 0);
    check("reset gnak_eff", 32'(gnak_eff), 0);
    check("reset ep_ena", 32'(ep_ena), 0);
    check("reset ep_disd", 32'(ep_disd), 0);
  endtask

  task automatic t_enable();
    ep_write(0, 1, 0, 0, 0);
    ep_write(1, 1, 0, 0, 0);
    check("R4 ep_ena", 32'(ep_ena), 32'h3);
    check("R10 other eps untouched", 32'(ep_dis | ep_nak), 0);
    check("R3 accept when idle", 32'(out_accept), 32'h3);
  endtask

  task automatic t_gnak_busy_fifo();
    rxf_level = 8'd5;
    pulse_set();
    check("R1 gnak_req", 32'(gnak_req), 1);
    check("R1 out_accept blocked", 32'(out_accept), 0);
    ep_write(1, 1, 1, 1, 0);
    check("R5 ep_dis set", 32'(ep_dis), 32'h2);
    check("R5 ep_nak set", 32'(ep_nak), 32'h2);
    step(3);
    check("R2 eff low while fifo busy", 32'(gnak_eff), 0);
    check("R5 still enabled while pending", 32'(ep_ena), 32'h3);
    check("R5 no disd while pending", 32'(ep_disd), 0);
    rxf_level = 8'd0;
    step(1);
    check("R2 eff rises", 32'(gnak_eff), 1);
    check("R6 ena not yet cleared", 32'(ep_ena), 32'h3);
    step(1);
    check("R6 ena cleared", 32'(ep_ena), 32'h1);
    check("R6 dis cleared", 32'(ep_dis), 0);
    check("R6 disd set", 32'(ep_disd), 32'h2);
  endtask

  task automatic t_ignore_disabled();
    ep_write(2, 1, 1, 0, 0);
    check("R9 ena unchanged", 32'(ep_ena), 32'h1);
    check("R9 dis unchanged", 32'(ep_dis), 0);
    step(1);
    check("R9 no disd", 32'(ep_disd), 32'h2);
  endtask

  task automatic t_disd_clear();
    disd_clr = 4'h1; step(1); disd_clr = '0;
    check("R7 other clear ignored", 32'(ep_disd), 32'h2);
    step(2);
    check("R7 sticky", 32'(ep_disd), 32'h2);
    disd_clr = 4'h2; step(1); disd_clr = '0;
    check("R7 cleared", 32'(ep_disd), 0);
  endtask

  task automatic t_release();
    pulse_clr();
    check("R3 req dropped", 32'(gnak_req), 0);
    check("R3 eff dropped", 32'(gnak_eff), 0);
    check("R3 accept resumes", 32'(out_accept), 32'h1);
  endtask

  task automatic t_nak();
    check("R8 nak kept after stop", 32'(ep_nak), 32'h2);
    ep_write(1, 0, 0, 1, 1);
    check("R8 snak wins over cnak", 32'(ep_nak), 32'h2);
    ep_write(1, 0, 0, 0, 1);
    check("R8 cnak clears", 32'(ep_nak), 0);
    ep_write(1, 1, 0, 0, 0);
    check("R3 re-enabled ep accepts", 32'(out_accept), 32'h3);
  endtask

  task automatic t_empty_set();
    pulse_set();
    check("R2 eff one edge later", 32'(gnak_eff), 0);
    step(1);
    check("R2 eff with empty fifo", 32'(gnak_eff), 1);
    pulse_clr();
    check("R3 eff dropped again", 32'(gnak_eff), 0);
  endtask

  initial begin
    rst_n = 1'b0; gnak_set = 0; gnak_clr = 0; rxf_level = '0;
    wr_stb = 0; wr_sel = '0; wr_ena = 0; wr_dis = 0; wr_snak = 0; wr_cnak = 0;
    disd_clr = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_enable();
    t_gnak_busy_fifo();
    t_ignore_disabled();
    t_disd_clear();
    t_release();
    t_nak();
    t_empty_set();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule